// File: doc/BRIEF.md
# Pulse-Position Downlink Symbol Decoder

This block sits behind the demodulator of a contactless receiver. Its input is a digitised carrier-pause signal, sampled on a clock taken from the carrier. Requests arrive as pulse-position coded frames. Each symbol period holds four slots, and the slot that carries the pause selects a two-bit value. The decoder finds the start delimiter and resynchronises a free-running slot counter to it. It then turns each symbol period into two bits, packs four symbols into a byte, and presents the bytes with one-cycle frame-start, frame-end and error strobes. CRC checking is left to the logic downstream.

Time is counted in half-slots, each half of one slot (a pause lasts one half-slot), so a symbol period is eight half-slots. Each half-slot is classified once, at its midpoint. Data pauses fall in odd half-slots and delimiter pauses fall in even ones. A start delimiter that belongs to the slower 1-out-of-256 coding is recognised and the whole request is passed over silently. A malformed frame raises the error strobe, and the rest of that frame is dropped.

Top module: `ppm_downlink_decoder`

## Requirements
- R1: While reset is held and on the cycle after it, every strobe output is low.
- R2: After idle, a pause that begins in half-slot 0 and a second pause in half-slot 6 of the same eight half-slot window form a start delimiter. The block pulses `frame_start_o` once after the eighth half-slot, and the next window is the first symbol window.
- R3: A single pause in half-slot 2n+1 of a symbol window (the second half of slot n, n = 0..3) decodes to the two-bit value n.
- R4: The first symbol of each group of four supplies bits 1:0 of the byte and the fourth supplies bits 7:6. `byte_valid_o` pulses for one cycle with `byte_o` once the fourth symbol window has closed.
- R5: Pauses in half-slots 0 and 2 of a symbol window, with half-slots 1 and 3 free, end the frame: `frame_end_o` pulses once, and any incomplete byte is discarded without output.
- R6: A start delimiter with its second pause in half-slot 4 (the slower coding) produces no strobe of any kind. All later pauses are ignored until the input has stayed free of pause for QUIET_SLOTS slots.
- R7: Two pauses in one symbol window raise `error_o` and abort the frame. No further byte or frame end is reported for that frame.
- R8: Within a frame, a pause in half-slot 4 or 6, or in half-slot 2 without an end-delimiter pause in half-slot 0, raises `error_o` and aborts the frame.
- R9: A symbol window that closes with no pause raises `error_o` and aborts the frame.
- R10: A start delimiter with a pause in any half-slot other than 0, 4 or 6, or with half-slot 6 empty, raises `error_o` and gives no frame start.
- R11: At most one of the four strobes is high in any cycle.
- R12: After an aborted or ignored request and a quiet period of QUIET_SLOTS slots, the next well-formed frame decodes correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock derived from the carrier |
| rst | input | 1 | Synchronous active-high reset |
| pause_i | input | 1 | Digitised carrier pause, 1 while the carrier is paused |
| frame_start_o | output | 1 | One-cycle strobe when a start delimiter is accepted |
| byte_valid_o | output | 1 | One-cycle strobe qualifying `byte_o` |
| byte_o | output | 8 | Assembled request byte |
| frame_end_o | output | 1 | One-cycle strobe when an end delimiter closes the frame |
| error_o | output | 1 | One-cycle strobe on a coding or framing error |

## Verification
The assertions check on every cycle that the strobes never overlap, and that a frame start comes only out of the delimiter hunt and a frame end only out of a frame. They also check that an error always leads to the ignore state, that the ignore state stays silent, and that a byte appears only after a symbol. Whether the decoded values are right can only be shown by the bench's scenarios. These cover an exhaustive sweep of all 256 byte values in one frame, a byte packed in the right bit order, partial-byte frame ends, and each malformed pattern. They also cover the slow-coding request being passed over, and recovery after the quiet period.

// File: rtl/ppm_dl_pkg.sv
package ppm_dl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HUNT,
        ST_DATA,
        ST_IGNORE
    } dl_state_e;

    typedef struct packed {
        logic       got;
        logic [1:0] val;
        logic       eod_a;
        logic       eod_b;
    } win_track_t;

    localparam logic [2:0] HS_EOD_A    = 3'd0;
    localparam logic [2:0] HS_EOD_B    = 3'd2;
    localparam logic [2:0] HS_SLOW_SOF = 3'd4;
    localparam logic [2:0] HS_FAST_SOF = 3'd6;

    function automatic logic hs_is_data(input logic [2:0] hs);
        return hs[0];
    endfunction

    function automatic logic [1:0] hs_to_sym(input logic [2:0] hs);
        return hs[2:1];
    endfunction

endpackage

// File: rtl/dl_timebase.sv
module dl_timebase #(
    parameter int HALF_CYC = 128
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sync_i,
    output logic [2:0] hs_o,
    output logic       mid_o,
    output logic       half_win_last_o,
    output logic       win_last_o
);
    localparam int HB  = $clog2(HALF_CYC);
    localparam int CW  = HB + 3;
    localparam int WIN = 8 * HALF_CYC;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (sync_i) begin
            cnt <= CW'(1);
        end else if (cnt == CW'(WIN - 1)) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

    assign hs_o            = cnt[CW-1 -: 3];
    assign mid_o           = (cnt[HB-1:0] == HB'(HALF_CYC / 2));
    assign half_win_last_o = (cnt == CW'(4 * HALF_CYC - 1));
    assign win_last_o      = (cnt == CW'(WIN - 1));

endmodule

// File: rtl/dl_quiet.sv
module dl_quiet #(
    parameter int QUIET_CYC = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    input  logic pause_i,
    output logic done_o
);
    localparam int QW = $clog2(QUIET_CYC + 1);

    logic [QW-1:0] qcnt;

    always_ff @(posedge clk) begin
        if (rst || !run_i || pause_i) begin
            qcnt <= '0;
        end else if (qcnt != QW'(QUIET_CYC - 1)) begin
            qcnt <= qcnt + QW'(1);
        end
    end

    assign done_o = run_i && !pause_i && (qcnt == QW'(QUIET_CYC - 1));

endmodule

// File: rtl/dl_packer.sv
module dl_packer (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr_i,
    input  logic       sym_vld_i,
    input  logic [1:0] sym_i,
    output logic       byte_vld_o,
    output logic [7:0] byte_o
);
    logic [1:0] sc;
    logic [5:0] acc;

    always_ff @(posedge clk) begin
        if (rst) begin
            sc         <= '0;
            acc        <= '0;
            byte_vld_o <= 1'b0;
            byte_o     <= '0;
        end else begin
            byte_vld_o <= 1'b0;
            if (clr_i) begin
                sc <= '0;
            end else if (sym_vld_i) begin
                if (sc == 2'd3) begin
                    byte_o     <= {sym_i, acc};
                    byte_vld_o <= 1'b1;
                    sc         <= '0;
                end else begin
                    acc <= {sym_i, acc[5:2]};
                    sc  <= sc + 2'd1;
                end
            end
        end
    end

    AST_BYTE_NEEDS_SYM: assert property (@(posedge clk) disable iff (rst)
        byte_vld_o |-> $past(sym_vld_i)); // R4

endmodule

// File: rtl/ppm_downlink_decoder.sv
module ppm_downlink_decoder #(
    parameter int SLOT_CYC    = 256,
    parameter int QUIET_SLOTS = 520
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pause_i,
    output logic       frame_start_o,
    output logic       byte_valid_o,
    output logic [7:0] byte_o,
    output logic       frame_end_o,
    output logic       error_o
);
    import ppm_dl_pkg::*;

    localparam int HALF_CYC  = SLOT_CYC / 2;
    localparam int QUIET_CYC = QUIET_SLOTS * SLOT_CYC;

    dl_state_e  st;
    win_track_t trk;
    logic       pause_q;
    logic       hunt_ok;
    logic       sof_q, eof_q, err_q;
    logic       sym_vld;
    logic [1:0] sym_val;

    logic [2:0] hs;
    logic       mid, half_last, win_last;
    logic       sync, quiet_done;

    assign sync = (st == ST_IDLE) && pause_i && !pause_q;

    dl_timebase #(.HALF_CYC(HALF_CYC)) tb_i (
        .clk             (clk),
        .rst             (rst),
        .sync_i          (sync),
        .hs_o            (hs),
        .mid_o           (mid),
        .half_win_last_o (half_last),
        .win_last_o      (win_last)
    );

    dl_quiet #(.QUIET_CYC(QUIET_CYC)) quiet_i (
        .clk     (clk),
        .rst     (rst),
        .run_i   (st == ST_IGNORE),
        .pause_i (pause_i),
        .done_o  (quiet_done)
    );

    dl_packer pack_i (
        .clk        (clk),
        .rst        (rst),
        .clr_i      (st != ST_DATA),
        .sym_vld_i  (sym_vld),
        .sym_i      (sym_val),
        .byte_vld_o (byte_valid_o),
        .byte_o     (byte_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            trk     <= '0;
            pause_q <= 1'b0;
            hunt_ok <= 1'b0;
            sof_q   <= 1'b0;
            eof_q   <= 1'b0;
            err_q   <= 1'b0;
            sym_vld <= 1'b0;
            sym_val <= '0;
        end else begin
            pause_q <= pause_i;
            sof_q   <= 1'b0;
            eof_q   <= 1'b0;
            err_q   <= 1'b0;
            sym_vld <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (sync) begin
                        st      <= ST_HUNT;
                        hunt_ok <= 1'b0;
                    end
                end
                ST_HUNT: begin
                    if (mid && pause_i && hs != HS_EOD_A) begin
                        if (hs == HS_SLOW_SOF) begin
                            st <= ST_IGNORE;
                        end else if (hs == HS_FAST_SOF) begin
                            hunt_ok <= 1'b1;
                        end else begin
                            err_q <= 1'b1;
                            st    <= ST_IGNORE;
                        end
                    end else if (win_last) begin
                        if (hunt_ok) begin
                            sof_q <= 1'b1;
                            st    <= ST_DATA;
                            trk   <= '0;
                        end else begin
                            err_q <= 1'b1;
                            st    <= ST_IGNORE;
                        end
                    end
                end
                ST_DATA: begin
                    if (mid && pause_i) begin
                        if (hs_is_data(hs)) begin
                            if (trk.got || trk.eod_a) begin
                                err_q <= 1'b1;
                                st    <= ST_IGNORE;
                            end else begin
                                trk.got <= 1'b1;
                                trk.val <= hs_to_sym(hs);
                            end
                        end else if (hs == HS_EOD_A) begin
                            trk.eod_a <= 1'b1;
                        end else if (hs == HS_EOD_B && trk.eod_a) begin
                            trk.eod_b <= 1'b1;
                        end else begin
                            err_q <= 1'b1;
                            st    <= ST_IGNORE;
                        end
                    end else if (half_last && trk.eod_a) begin
                        trk <= '0;
                        if (trk.eod_b) begin
                            eof_q <= 1'b1;
                            st    <= ST_IDLE;
                        end else begin
                            err_q <= 1'b1;
                            st    <= ST_IGNORE;
                        end
                    end else if (win_last) begin
                        trk <= '0;
                        if (trk.got) begin
                            sym_vld <= 1'b1;
                            sym_val <= trk.val;
                        end else begin
                            err_q <= 1'b1;
                            st    <= ST_IGNORE;
                        end
                    end
                end
                ST_IGNORE: begin
                    if (quiet_done) begin
                        st <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign frame_start_o = sof_q;
    assign frame_end_o   = eof_q;
    assign error_o       = err_q;

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sof_q, eof_q, err_q, byte_valid_o})); // R11
    AST_SOF_FROM_HUNT: assert property (@(posedge clk) disable iff (rst)
        sof_q |-> ($past(st) == ST_HUNT) && (st == ST_DATA)); // R2
    AST_EOF_FROM_DATA: assert property (@(posedge clk) disable iff (rst)
        eof_q |-> ($past(st) == ST_DATA) && (st == ST_IDLE)); // R5
    AST_ERR_TO_IGNORE: assert property (@(posedge clk) disable iff (rst)
        err_q |-> (st == ST_IGNORE)); // R7
    AST_IGNORE_SILENT: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IGNORE && $past(st) == ST_IGNORE)
            |-> !sof_q && !eof_q && !err_q && !byte_valid_o); // R6

endmodule

// File: tb/ppm_downlink_decoder_tb_top.sv
module ppm_downlink_decoder_tb_top;

    localparam int SLOT = 8;
    localparam int HALF = SLOT / 2;
    localparam int QS   = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pause = 1'b0;
    logic       fs, bv, fe, er;
    logic [7:0] bd;

    int n_checks = 0;
    int n_err    = 0;
    int n_sof = 0, n_eof = 0, n_erq = 0, n_rx = 0;
    int rx [0:511];
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ppm_downlink_decoder #(.SLOT_CYC(SLOT), .QUIET_SLOTS(QS)) dut_i (
        .clk           (clk),
        .rst           (rst),
        .pause_i       (pause),
        .frame_start_o (fs),
        .byte_valid_o  (bv),
        .byte_o        (bd),
        .frame_end_o   (fe),
        .error_o       (er)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (fs) n_sof++;
            if (fe) n_eof++;
            if (er) n_erq++;
            if (bv) begin
                if (n_rx < 512) rx[n_rx] = int'(bd);
                n_rx++;
            end
        end
    end

    task automatic check_eq(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clr_counts();
        n_sof = 0; n_eof = 0; n_erq = 0; n_rx = 0;
    endtask

    task automatic hs(input bit p);
        pause = p;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic gap(input int n);
        for (int i = 0; i < n; i++) hs(1'b0);
    endtask

    task automatic send_sof();
        hs(1); gap(5); hs(1); hs(0);
    endtask

    task automatic send_sym(input int s);
        for (int k = 0; k < 8; k++) hs(k == 2 * s + 1);
    endtask

    task automatic send_byte(input int b);
        for (int j = 0; j < 4; j++) send_sym((b >> (2 * j)) & 3);
    endtask

    task automatic send_eof();
        hs(1); hs(0); hs(1); hs(0);
    endtask

    task automatic expect_counts(input string req, input int sof, input int rxn,
                                 input int eof, input int err);
        #1;
        check_eq({req, " frame_start count"}, n_sof, sof);
        check_eq({req, " byte count"}, n_rx, rxn);
        check_eq({req, " frame_end count"}, n_eof, eof);
        check_eq({req, " error count"}, n_erq, err);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        check_eq("R1 strobes in reset", int'({fs, bv, fe, er}), 0);
        rst = 1'b0;
        @(negedge clk);
        check_eq("R1 strobes after reset", int'({fs, bv, fe, er}), 0);
        gap(4);

        // R2 R3 R4: exhaustive byte sweep in one frame
        clr_counts();
        send_sof();
        for (int b = 0; b < 256; b++) send_byte(b);
        send_eof();
        gap(4);
        expect_counts("R2/R5 sweep", 1, 256, 1, 0);
        for (int b = 0; b < 256; b++) check_eq("R3 R4 byte value", rx[b], b);

        // R4 bit order: symbols 3,0,1,2 -> 0b10_01_00_11
        clr_counts();
        send_sof(); send_sym(3); send_sym(0); send_sym(1); send_sym(2);
        send_eof(); gap(4);
        expect_counts("R4 order", 1, 1, 1, 0);
        check_eq("R4 first symbol in low bits", rx[0], 8'h93);

        // R5 partial byte discarded at frame end
        clr_counts();
        send_sof(); send_byte(8'h5A); send_sym(1); send_sym(2);
        send_eof(); gap(4);
        expect_counts("R5 partial", 1, 1, 1, 0);
        check_eq("R5 full byte kept", rx[0], 8'h5A);

        // R7 two pauses in one window
        clr_counts();
        send_sof(); send_sym(1);
        hs(0); hs(1); hs(0); hs(0); hs(0); hs(1); hs(0); hs(0);
        send_byte(8'hFF); send_eof(); gap(20);
        expect_counts("R7 double pause", 1, 0, 0, 1);

        // R8 pause in even half-slot 4
        clr_counts();
        send_sof(); send_byte(8'h11);
        hs(0); hs(0); hs(0); hs(0); hs(1); hs(0); hs(0); hs(0);
        send_eof(); gap(20);
        expect_counts("R8 half-slot 4", 1, 1, 0, 1);

        // R8 pause in half-slot 2 without end-delimiter start
        clr_counts();
        send_sof();
        hs(0); hs(0); hs(1); hs(0); hs(0); hs(0); hs(0); hs(0);
        gap(20);
        expect_counts("R8 half-slot 2 alone", 1, 0, 0, 1);

        // R9 empty symbol window
        clr_counts();
        send_sof(); send_sym(2); gap(8); send_sym(1); send_eof(); gap(20);
        expect_counts("R9 empty window", 1, 0, 0, 1);

        // R5/R9 end delimiter missing second pause
        clr_counts();
        send_sof(); send_sym(2); hs(1); gap(20);
        expect_counts("R5 broken end delimiter", 1, 0, 0, 1);

        // R10 malformed start delimiter
        clr_counts();
        hs(1); hs(0); hs(0); hs(1); gap(20);
        expect_counts("R10 bad delimiter", 0, 0, 0, 1);
        clr_counts();
        hs(1); gap(7); gap(20);
        expect_counts("R10 lone pause", 0, 0, 0, 1);

        // R6 slow-coding request ignored
        clr_counts();
        hs(1); hs(0); hs(0); hs(0); hs(1);
        for (int i = 0; i < 6; i++) begin gap(9); hs(1); end
        gap(20);
        expect_counts("R6 slow coding", 0, 0, 0, 0);

        // R12 recovery after ignore
        clr_counts();
        send_sof(); send_byte(8'hA5); send_byte(8'h3C); send_eof(); gap(4);
        expect_counts("R12 recovery", 1, 2, 1, 0);
        check_eq("R12 byte 0", rx[0], 8'hA5);
        check_eq("R12 byte 1", rx[1], 8'h3C);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule